// File: doc/BRIEF.md
# Indexed-Mask Interrupt Controller Unit

This unit collects 64 interrupt request lines and reports the single most urgent one to the processor. Each source carries a small priority level. A source may win only when three things hold: its request is high, its mask bit is clear and its level is non-zero. The winner is the source with the highest level. When two or more sources share that level, the source with the lower index wins. The index, level and a global source number of the winner are presented on registered outputs.

Software never writes the 64-bit mask as a whole. It writes a source number to one of two byte-wide ports: the set port masks that source and the clear port unmasks it. The byte value 0xFF on either port acts on all sources at once. Each source's level is written through its own byte address, inside a window placed at a base offset. Several units can serve a wider source space. The parameter `UNIT_ID` gives the unit's place in that space, and the unit adds `UNIT_ID*64` to the local winner index to form the global number.

Top module: `intc_idxmask`

## Requirements
- R1: While reset is asserted and after it is released, every source is masked and every level is 0. `irq_valid`, `irq_id`, `irq_level` and `irq_gid` read 0 until a source becomes eligible.
- R2: A write to address 0x10 with a data byte other than 0xFF masks exactly one source. That source is the one numbered by data bits [5:0]; data bits [7:6] are ignored.
- R3: A write to address 0x11 with a data byte other than 0xFF unmasks exactly one source, numbered by data bits [5:0]. All other mask bits keep their values.
- R4: Writing 0xFF to address 0x10 masks all 64 sources in one write.
- R5: Writing 0xFF to address 0x11 unmasks all 64 sources in one write.
- R6: A write to address 0x40+n, for n from 0 to 63, sets the level of source n to data bits [2:0]. A source whose level is 0 never wins and never raises `irq_valid`.
- R7: Among the eligible sources (request high, unmasked, level non-zero), the one with the highest level is reported.
- R8: When several eligible sources share the highest level, the one with the lowest index is reported.
- R9: The outputs are registered. A request change that is set up before clock edge k shows on the outputs after edge k. A register write sampled at edge k shows on the outputs after edge k+1.
- R10: While `irq_valid` is 1, `irq_gid` equals `UNIT_ID*64 + irq_id`. While it is 0, `irq_gid` is 0.
- R11: A write to any address other than 0x10, 0x11 or 0x40..0x7F changes neither the mask nor any level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 8 | Byte address of the write |
| wr_data | input | 8 | Byte written |
| irq_req | input | 64 | Request lines, one per source |
| irq_valid | output | 1 | An eligible source exists |
| irq_id | output | 6 | Local index of the winning source |
| irq_level | output | 3 | Level of the winning source |
| irq_gid | output | 8 | Global source number of the winner |

## Verification
Two events can meet at the same clock edge: a change of a request line and a mask write that names the same source. The bench raises a request in the same cycle as the clear-port write that unmasks it. It then expects the outputs to stay idle for one edge, because the old mask still applies, and the source to be reported after the following edge. Random runs mix request changes with level, mask and stray writes. After the outputs settle, each result is compared with a winner computed from a bench-side model of the mask and levels.

// File: rtl/intc_idxmask_pkg.sv
package intc_idxmask_pkg;
   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_SET  = 2'd1,
      OP_CLR  = 2'd2,
      OP_LVL  = 2'd3
   } intc_op_e;
endpackage

// File: rtl/intc_mask_bank.sv
module intc_mask_bank
   import intc_idxmask_pkg::*;
#(
   parameter int NSRC  = 64,
   parameter int IDX_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  intc_op_e         op,
   input  logic             all_sel,
   input  logic [IDX_W-1:0] idx,
   output logic [NSRC-1:0]  mask_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '1;
      end else begin
         case (op)
            OP_SET: begin
               if (all_sel) mask_q <= '1;
               else         mask_q[idx] <= 1'b1;
            end
            OP_CLR: begin
               if (all_sel) mask_q <= '0;
               else         mask_q[idx] <= 1'b0;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/intc_level_file.sv
module intc_level_file #(
   parameter int NSRC  = 64,
   parameter int IDX_W = 6,
   parameter int LVL_W = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   we,
   input  logic [IDX_W-1:0]       idx,
   input  logic [LVL_W-1:0]       din,
   output logic [NSRC*LVL_W-1:0]  lvl_flat
);
   for (genvar g = 0; g < NSRC; g++) begin : g_src
      logic [LVL_W-1:0] lvl_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                            lvl_q <= '0;
         else if (we && (idx == IDX_W'(g)))     lvl_q <= din;
      end
      assign lvl_flat[g*LVL_W +: LVL_W] = lvl_q;
   end
endmodule

// File: rtl/intc_prio_pick.sv
module intc_prio_pick #(
   parameter int NSRC  = 64,
   parameter int IDX_W = 6,
   parameter int LVL_W = 3
) (
   input  logic [NSRC-1:0]        req,
   input  logic [NSRC-1:0]        mask,
   input  logic [NSRC*LVL_W-1:0]  lvl_flat,
   output logic                   found,
   output logic [IDX_W-1:0]       win_idx,
   output logic [LVL_W-1:0]       win_lvl
);
   // Scan from the top index down with >= so that, on equal levels,
   // the lower index is the last one taken.
   always_comb begin
      found   = 1'b0;
      win_idx = '0;
      win_lvl = '0;
      for (int i = NSRC - 1; i >= 0; i--) begin
         if (req[i] && !mask[i] && (lvl_flat[i*LVL_W +: LVL_W] != '0) &&
             (lvl_flat[i*LVL_W +: LVL_W] >= win_lvl)) begin
            found   = 1'b1;
            win_idx = IDX_W'(i);
            win_lvl = lvl_flat[i*LVL_W +: LVL_W];
         end
      end
   end
endmodule

// File: rtl/intc_idxmask.sv
module intc_idxmask
   import intc_idxmask_pkg::*;
#(
   parameter int NSRC     = 64,
   parameter int LVL_W    = 3,
   parameter int ADDR_W   = 8,
   parameter int GID_W    = 8,
   parameter int UNIT_ID  = 0,
   parameter int SET_OFS  = 'h10,
   parameter int CLR_OFS  = 'h11,
   parameter int LVL_BASE = 'h40,
   localparam int IDX_W   = $clog2(NSRC)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic [NSRC-1:0]   irq_req,
   output logic              irq_valid,
   output logic [IDX_W-1:0]  irq_id,
   output logic [LVL_W-1:0]  irq_level,
   output logic [GID_W-1:0]  irq_gid
);
   localparam int                  HI_W   = ADDR_W - IDX_W;
   localparam logic [HI_W-1:0]     LVL_HI = HI_W'(LVL_BASE / NSRC);
   localparam logic [GID_W-1:0]    GBASE  = GID_W'(UNIT_ID * NSRC);

   // Elaboration-time parameter checks
   if (NSRC < 2 || NSRC > 128 || (1 << IDX_W) != NSRC) begin : g_bad_nsrc
      $error("NSRC must be a power of two from 2 to 128");
   end
   if (LVL_W < 1 || LVL_W > 8) begin : g_bad_lvl
      $error("LVL_W must be 1..8");
   end
   if ((LVL_BASE % NSRC) != 0 || (LVL_BASE + NSRC) > (1 << ADDR_W)) begin : g_bad_base
      $error("level window must be aligned and inside the address space");
   end
   if (SET_OFS == CLR_OFS ||
       (SET_OFS >= LVL_BASE && SET_OFS < LVL_BASE + NSRC) ||
       (CLR_OFS >= LVL_BASE && CLR_OFS < LVL_BASE + NSRC)) begin : g_bad_ofs
      $error("mask ports must be distinct and outside the level window");
   end
   if ((UNIT_ID + 1) * NSRC > (1 << GID_W)) begin : g_bad_gid
      $error("GID_W too narrow for UNIT_ID");
   end

   // Write decode
   intc_op_e op;
   logic     hit_lvl;
   assign hit_lvl = (wr_addr[ADDR_W-1:IDX_W] == LVL_HI);

   always_comb begin
      op = OP_NONE;
      if (wr_en) begin
         if (wr_addr == ADDR_W'(SET_OFS))      op = OP_SET;
         else if (wr_addr == ADDR_W'(CLR_OFS)) op = OP_CLR;
         else if (hit_lvl)                     op = OP_LVL;
      end
   end

   logic [NSRC-1:0]        mask_q;
   logic [NSRC*LVL_W-1:0]  lvl_flat;
   logic                   found;
   logic [IDX_W-1:0]       win_idx;
   logic [LVL_W-1:0]       win_lvl;

   intc_mask_bank #(.NSRC(NSRC), .IDX_W(IDX_W)) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .op      (op),
      .all_sel (wr_data == 8'hFF),
      .idx     (wr_data[IDX_W-1:0]),
      .mask_q  (mask_q)
   );

   intc_level_file #(.NSRC(NSRC), .IDX_W(IDX_W), .LVL_W(LVL_W)) u_lvl (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (op == OP_LVL),
      .idx      (wr_addr[IDX_W-1:0]),
      .din      (wr_data[LVL_W-1:0]),
      .lvl_flat (lvl_flat)
   );

   intc_prio_pick #(.NSRC(NSRC), .IDX_W(IDX_W), .LVL_W(LVL_W)) u_pick (
      .req      (irq_req),
      .mask     (mask_q),
      .lvl_flat (lvl_flat),
      .found    (found),
      .win_idx  (win_idx),
      .win_lvl  (win_lvl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_valid <= 1'b0;
         irq_id    <= '0;
         irq_level <= '0;
         irq_gid   <= '0;
      end else begin
         irq_valid <= found;
         irq_id    <= win_idx;
         irq_level <= win_lvl;
         irq_gid   <= found ? (GBASE + GID_W'(win_idx)) : '0;
      end
   end
endmodule

// File: rtl/intc_idxmask_chk.sv
module intc_idxmask_chk #(
   parameter int NSRC    = 64,
   parameter int LVL_W   = 3,
   parameter int ADDR_W  = 8,
   parameter int SET_OFS = 'h10,
   parameter int CLR_OFS = 'h11,
   localparam int IDX_W  = $clog2(NSRC)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [7:0]        wr_data,
   input logic [NSRC-1:0]   irq_req,
   input logic [NSRC-1:0]   mask_q,
   input logic              irq_valid,
   input logic [IDX_W-1:0]  irq_id,
   input logic [LVL_W-1:0]  irq_level
);
   logic [NSRC-1:0] mask_d;
   logic [NSRC-1:0] req_d;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_d <= '1;
         req_d  <= '0;
      end else begin
         mask_d <= mask_q;
         req_d  <= irq_req;
      end
   end

   a_r2_set_one: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(SET_OFS) && wr_data != 8'hFF)
      |=> mask_q[$past(wr_data[IDX_W-1:0])]);

   a_r3_clr_one: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(CLR_OFS) && wr_data != 8'hFF)
      |=> !mask_q[$past(wr_data[IDX_W-1:0])]);

   a_r4_set_all: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(SET_OFS) && wr_data == 8'hFF)
      |=> (mask_q == '1));

   a_r5_clr_all: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(CLR_OFS) && wr_data == 8'hFF)
      |=> (mask_q == '0));

   a_r6_level_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> (irq_level != '0));

   a_r7_winner_eligible: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> (req_d[irq_id] && !mask_d[irq_id]));

   a_r9_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
      (req_d == '0) |-> !irq_valid);
endmodule

bind intc_idxmask intc_idxmask_chk #(
   .NSRC(NSRC), .LVL_W(LVL_W), .ADDR_W(ADDR_W),
   .SET_OFS(SET_OFS), .CLR_OFS(CLR_OFS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .wr_data(wr_data), .irq_req(irq_req), .mask_q(mask_q),
   .irq_valid(irq_valid), .irq_id(irq_id), .irq_level(irq_level)
);

// File: tb/intc_idxmask_tb.sv
module intc_idxmask_tb_top;
   localparam int UID = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic [63:0] irq_req = '0;
   logic        irq_valid;
   logic [5:0]  irq_id;
   logic [2:0]  irq_level;
   logic [7:0]  irq_gid;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   bit       m_mask [64];
   bit [2:0] m_lvl  [64];

   intc_idxmask #(.UNIT_ID(UID)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .irq_req(irq_req), .irq_valid(irq_valid),
      .irq_id(irq_id), .irq_level(irq_level), .irq_gid(irq_gid)
   );

   always #4 clk = ~clk;

   function automatic void model_wr(input logic [7:0] a, input logic [7:0] d);
      if (a == 8'h10) begin
         if (d == 8'hFF) for (int i = 0; i < 64; i++) m_mask[i] = 1'b1;
         else m_mask[d[5:0]] = 1'b1;
      end else if (a == 8'h11) begin
         if (d == 8'hFF) for (int i = 0; i < 64; i++) m_mask[i] = 1'b0;
         else m_mask[d[5:0]] = 1'b0;
      end else if (a[7:6] == 2'b01) begin
         m_lvl[a[5:0]] = d[2:0];
      end
   endfunction

   // returns {valid, id[5:0], level[2:0]}
   function automatic logic [9:0] exp_pick(input logic [63:0] r);
      logic       f = 1'b0;
      logic [5:0] bi = '0;
      logic [2:0] bl = '0;
      for (int i = 0; i < 64; i++) begin
         if (r[i] && !m_mask[i] && m_lvl[i] != 0 && m_lvl[i] > bl) begin
            f = 1'b1; bi = 6'(i); bl = m_lvl[i];
         end
      end
      return {f, bi, bl};
   endfunction

   task automatic check(input string tag);
      logic [9:0] e;
      logic [7:0] eg;
      e  = exp_pick(irq_req);
      eg = e[9] ? 8'(UID * 64 + int'(e[8:3])) : 8'd0;
      n_cmp++;
      if (irq_valid !== e[9] || irq_id !== e[8:3] || irq_level !== e[2:0] || irq_gid !== eg) begin
         n_bad++;
         $display("FAIL %s: got v=%0b id=%0d lvl=%0d gid=%0d exp v=%0b id=%0d lvl=%0d gid=%0d",
                  tag, irq_valid, irq_id, irq_level, irq_gid, e[9], e[8:3], e[2:0], eg);
      end
   endtask

   // Write sampled at one edge; returns at the negedge right after it.
   task automatic wr_raw(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      wr_raw(a, d);
      model_wr(a, d);
      @(negedge clk);
   endtask

   task automatic set_req(input logic [63:0] r);
      @(negedge clk);
      irq_req = r;
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(8 * 150000);
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      finish_run();
   end

   initial begin
      logic [7:0] a;
      for (int i = 0; i < 64; i++) begin m_mask[i] = 1'b1; m_lvl[i] = 3'd0; end
      void'($urandom(32'd5150));
      repeat (3) @(negedge clk);
      check("R1 in reset");
      rst_n = 1'b1;
      set_req('1);
      check("R1 after reset all masked");

      wr(8'h11, 8'hFF);
      check("R6 level zero never requests (R5 unmask all)");

      wr(8'h4A, 8'h03); wr(8'h54, 8'h03); wr(8'h45, 8'h01);
      check("R8 tie 10 vs 20 lowest index");
      wr(8'h68, 8'hF6);
      check("R7 higher level 6 at src 40, R6 low bits");
      wr(8'h10, 8'hE8);
      check("R2 set index 40 via low bits");
      wr(8'h11, 8'h28);
      check("R3 clear index 40");
      wr(8'h10, 8'hFF);
      check("R4 set all masks");

      wr(8'h12, 8'hFF); wr(8'h3F, 8'hFF); wr(8'h80, 8'h11);
      check("R11 stray writes ignored");

      // R9: register write visible only one edge after it is sampled
      wr_raw(8'h11, 8'h0A);
      check("R9 old mask still applies");
      model_wr(8'h11, 8'h0A);
      @(negedge clk);
      check("R9 unmask visible next edge");
      @(negedge clk);
      irq_req = 64'h0;
      @(negedge clk);
      check("R9 request drop seen after one edge");

      // same-cycle request rise and unmask of that source
      wr(8'h61, 8'h04);
      @(negedge clk);
      irq_req = 64'd1 << 33;
      wr_en = 1'b1; wr_addr = 8'h11; wr_data = 8'd33;
      @(negedge clk);
      wr_en = 1'b0;
      check("R9 simultaneous: mask still old");
      model_wr(8'h11, 8'd33);
      @(negedge clk);
      check("R3 R10 simultaneous: source 33 reported");

      for (int it = 0; it < 500; it++) begin
         case ($urandom % 8)
            0, 1, 2: wr(8'h40 | 8'($urandom % 64), 8'($urandom));
            3: wr(8'h10, ($urandom % 16 == 0) ? 8'hFF : 8'($urandom));
            4: wr(8'h11, ($urandom % 16 == 0) ? 8'hFF : 8'($urandom));
            5: begin
               a = 8'($urandom);
               if (a == 8'h10 || a == 8'h11 || a[7:6] == 2'b01) a = 8'h20;
               wr(a, 8'($urandom));
            end
            default: set_req({32'($urandom), 32'($urandom)} & {32'($urandom), 32'($urandom)});
         endcase
         @(negedge clk);
         check("R7 R8 R10 random");
      end
      finish_run();
   end
endmodule